// File: doc/BRIEF.md
# 48-bit Frame-Synchronous Additive Scrambler

This block whitens a transport stream that moves 48 bits per clock. It XORs each valid word with the next 48 bits of a pseudo-random keystream, which a 16-bit linear feedback shift register produces. The register is advanced 48 positions per clock by a parallel step built from logic.

The sequence is locked to the frame. The word that carries the frame alignment pattern is marked by a `frame_start` strobe. That word passes through unchanged, and it resets the generator, so the keystream begins again at the first bit that follows the alignment bytes. An additive scrambler is its own inverse, so one instance can sit in the transmit path and a second identical instance in the receive path. Both see the same frame starts and so cancel each other.

When there is no valid word, the output idles at all ones with the valid flag low, and the keystream holds its position.

Top module: `scr48_frame`

## Requirements
- R1: `valid_out` equals `valid_in` delayed by exactly one clock; `data_out` is registered, with one clock of latency.
- R2: A clock with `valid_in` low makes `data_out` equal 48'hFFFF_FFFF_FFFF and `valid_out` 0 on the next clock.
- R3: A clock with `valid_in` and `frame_start` both high passes `data_in` to `data_out` unchanged and loads the generator with all ones (16'hFFFF).
- R4: Each generator step emits state bit 15 as the keystream bit, then shifts the state left by one, inserting s[15]^s[11]^s[2]^s[0] at bit 0 (polynomial x^16+x^12+x^3+x+1).
- R5: The first keystream bit of a word scrambles data bit 47, and the last scrambles bit 0.
- R6: Each valid word that is not a frame start is XORed with the keystream and advances the generator by exactly 48 steps. Consecutive words therefore use consecutive keystream segments.
- R7: Clocks with `valid_in` low do not advance the generator.
- R8: `frame_start` while `valid_in` is low has no effect on the keystream.
- R9: A new frame start in the middle of a stream restarts the keystream, so the words that follow it use the same keystream as the start of the first frame.
- R10: Feeding the scrambled stream back through the block, with the same frame starts, returns the original data.
- R11: Synchronous active-low reset sets `data_out` to all ones, `valid_out` to 0 and the generator to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Marks the alignment word of a frame; qualified by valid_in |
| valid_in | input | 1 | Input word is valid |
| data_in | input | 48 | Input word |
| data_out | output | 48 | Scrambled word, pass-through alignment word, or all ones when idle |
| valid_out | output | 1 | Output word is valid |

## Verification
Idle gaps are placed in the middle of a frame, because a generator that kept stepping through them would corrupt every word after the gap. A frame start is sent with valid low to catch a design that reloads on an unqualified strobe; the words after it would then repeat the frame's opening keystream. A second frame start in mid-stream is checked against the keystream of the first frame, which exposes a missing reload or a reload to the wrong seed. The bit order within each word and the exact step count per word are pinned by checking whole words against a model of the register. A reversed bit order or a wrong step count then shows up as wrong bits. A round trip through the block confirms that the alignment word is not scrambled and that the transform cancels itself.

// File: rtl/scr48_pkg.sv
// Shared constants for the 48-bit frame-synchronous scrambler.
// Assumes a Fibonacci-style register whose output is its top bit.
package scr48_pkg;
    localparam int          DATA_W = 48;
    localparam int          LFSR_W = 16;
    // Feedback taps on state bits 15, 11, 2, 0: x^16 + x^12 + x^3 + x + 1
    localparam logic [15:0] TAPS   = 16'h8805;
    localparam logic [15:0] SEED   = 16'hFFFF;
endpackage

// File: rtl/scr48_keystream.sv
// Parallel keystream generator: unrolls DATA_W single-bit register steps.
// The keystream bit of step i lands at word bit DATA_W-1-i (MSB first).
// Also returns the state after all DATA_W steps. Purely combinational.
module scr48_keystream #(
    parameter int               DATA_W = 48,
    parameter int               LFSR_W = 16,
    parameter logic [LFSR_W-1:0] TAPS  = 16'h8805
) (
    input  logic [LFSR_W-1:0] state_cur,
    output logic [DATA_W-1:0] key_word,
    output logic [LFSR_W-1:0] state_nxt
);
    logic [DATA_W:0][LFSR_W-1:0] chain;

    assign chain[0] = state_cur;

    // One register step per position: emit the top bit, shift in the feedback
    for (genvar i = 0; i < DATA_W; i++) begin : g_step
        assign key_word[DATA_W-1-i] = chain[i][LFSR_W-1];
        assign chain[i+1] = {chain[i][LFSR_W-2:0], ^(chain[i] & TAPS)};
    end

    assign state_nxt = chain[DATA_W];
endmodule

// File: rtl/scr48_state_reg.sv
// Generator state register. A reload takes priority over an advance.
// Holds its value when neither is requested. Synchronous active-low reset to SEED.
module scr48_state_reg #(
    parameter int                LFSR_W = 16,
    parameter logic [LFSR_W-1:0] SEED   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              advance,
    input  logic [LFSR_W-1:0] state_nxt,
    output logic [LFSR_W-1:0] state_q
);
    // Update the state: reset, reload at frame start, or step by one word
    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= SEED;
        else if (reload)  state_q <= SEED;
        else if (advance) state_q <= state_nxt;
    end
endmodule

// File: rtl/scr48_out_stage.sv
// Output register: XORs the word with the keystream, or bypasses it.
// Idles at all ones with valid low. One clock of latency.
module scr48_out_stage #(
    parameter int DATA_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic              bypass,
    input  logic [DATA_W-1:0] data_in,
    input  logic [DATA_W-1:0] key_word,
    output logic [DATA_W-1:0] data_out,
    output logic              valid_out
);
    // Register the output word and its valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out  <= '1;
            valid_out <= 1'b0;
        end else if (!valid_in) begin
            data_out  <= '1;
            valid_out <= 1'b0;
        end else begin
            data_out  <= bypass ? data_in : (data_in ^ key_word);
            valid_out <= 1'b1;
        end
    end
endmodule

// File: rtl/scr48_frame.sv
// Frame-synchronous additive scrambler/descrambler, one word per clock.
// Assumes frame_start marks the alignment word and is only honoured with valid_in.
// The same block serves both the transmit path and the receive path.
module scr48_frame
    import scr48_pkg::*;
#(
    parameter int                W  = DATA_W,
    parameter int                LW = LFSR_W,
    parameter logic [LW-1:0]     TP = TAPS,
    parameter logic [LW-1:0]     SD = SEED
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         valid_in,
    input  logic [W-1:0] data_in,
    output logic [W-1:0] data_out,
    output logic         valid_out
);
    logic [LW-1:0] lfsr_q;
    logic [LW-1:0] lfsr_nxt;
    logic [W-1:0]  key_word;
    logic          align_word;
    logic          data_word;

    // Qualify the strobe: only a valid alignment word restarts the sequence
    assign align_word = valid_in & frame_start;
    assign data_word  = valid_in & ~frame_start;

    scr48_keystream #(.DATA_W(W), .LFSR_W(LW), .TAPS(TP)) u_ks (
        .state_cur (lfsr_q),
        .key_word  (key_word),
        .state_nxt (lfsr_nxt)
    );

    scr48_state_reg #(.LFSR_W(LW), .SEED(SD)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (align_word),
        .advance   (data_word),
        .state_nxt (lfsr_nxt),
        .state_q   (lfsr_q)
    );

    scr48_out_stage #(.DATA_W(W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_in),
        .bypass    (frame_start),
        .data_in   (data_in),
        .key_word  (key_word),
        .data_out  (data_out),
        .valid_out (valid_out)
    );
endmodule

// File: rtl/scr48_frame_chk.sv
// Property checker for scr48_frame, attached with bind below.
module scr48_frame_chk #(
    parameter int W  = 48,
    parameter int LW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_start,
    input logic          valid_in,
    input logic [W-1:0]  data_in,
    input logic [W-1:0]  data_out,
    input logic          valid_out,
    input logic [LW-1:0] lfsr_q
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out); // R1
    AST_INVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out); // R1
    AST_IDLE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> (data_out == {W{1'b1}})); // R2
    AST_ALIGN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && frame_start) |=> (data_out == $past(data_in))); // R3
    AST_ALIGN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && frame_start) |=> (lfsr_q == {LW{1'b1}})); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(lfsr_q)); // R7
endmodule

bind scr48_frame scr48_frame_chk #(.W(W), .LW(LW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .valid_in    (valid_in),
    .data_in     (data_in),
    .data_out    (data_out),
    .valid_out   (valid_out),
    .lfsr_q      (lfsr_q)
);

// File: tb/sim_scr48_frame.sv
module sim_scr48_frame;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        valid_in = 1'b0;
    logic [47:0] data_in = '0;
    logic [47:0] data_out;
    logic        valid_out;

    int errors = 0;
    int checks = 0;
    logic [15:0] m_state = 16'hFFFF;

    always #4 clk = ~clk; // 125 MHz

    scr48_frame u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .valid_in(valid_in), .data_in(data_in),
        .data_out(data_out), .valid_out(valid_out)
    );

    typedef struct packed {
        logic        fs;
        logic        vin;
        logic [47:0] d;
    } vec_t;

    // Stimulus table; expected values come from the reference model
    localparam vec_t VEC [16] = '{
        '{1'b1, 1'b1, 48'hF6F6F6282828},  // R3 alignment passes, reload
        '{1'b0, 1'b1, 48'h000000000000},  // R4 R5 bare keystream from seed
        '{1'b0, 1'b1, 48'hFFFFFFFFFFFF},  // R6 next segment
        '{1'b0, 1'b1, 48'h123456789ABC},  // R6
        '{1'b0, 1'b0, 48'hDEADBEEF0000},  // R2 idle
        '{1'b0, 1'b0, 48'h000000000001},  // R2 R7 idle again
        '{1'b0, 1'b1, 48'hA5A5A5A5A5A5},  // R7 resumes where it stopped
        '{1'b1, 1'b0, 48'h555555555555},  // R8 strobe without valid
        '{1'b0, 1'b1, 48'h0F0F0F0F0F0F},  // R8 no restart happened
        '{1'b0, 1'b1, 48'h800000000001},  // R1 R6
        '{1'b1, 1'b1, 48'hF6F6F6282828},  // R9 mid-stream frame start
        '{1'b0, 1'b1, 48'h000000000000},  // R9 same keystream as first frame
        '{1'b0, 1'b1, 48'hFFFFFFFFFFFF},  // R9
        '{1'b0, 1'b0, 48'h0},             // R1 valid drops
        '{1'b0, 1'b1, 48'hCAFEF00D1234},  // R6
        '{1'b0, 1'b0, 48'h0}              // R2
    };

    function automatic logic [15:0] lstep(logic [15:0] s);
        return {s[14:0], s[15] ^ s[11] ^ s[2] ^ s[0]};
    endfunction

    task automatic check(string req, logic [47:0] got_d, logic [47:0] exp_d,
                         logic got_v, logic exp_v);
        checks++;
        if (got_d !== exp_d || got_v !== exp_v) begin
            errors++;
            $display("FAIL %s: data_out=%h valid_out=%b expected %h %b",
                     req, got_d, got_v, exp_d, exp_v);
        end
    endtask

    // Drive one word at the falling edge, check it at the next falling edge
    task automatic step(logic fs, logic vin, logic [47:0] d, string req,
                        output logic [47:0] got);
        logic [47:0] exp_d;
        logic [47:0] ks;
        logic        exp_v;
        frame_start = fs;
        valid_in    = vin;
        data_in     = d;
        exp_v = vin;
        exp_d = '1;
        if (vin && fs) begin
            exp_d   = d;
            m_state = 16'hFFFF;
        end else if (vin) begin
            for (int b = 47; b >= 0; b--) begin
                ks[b]   = m_state[15];
                m_state = lstep(m_state);
            end
            exp_d = d ^ ks;
        end
        @(negedge clk);
        got = data_out;
        check(req, data_out, exp_d, valid_out, exp_v);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        frame_start = 1'b0;
        valid_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R11", data_out, 48'hFFFFFFFFFFFF, valid_out, 1'b0);
        rst_n = 1'b1;
        m_state = 16'hFFFF;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [47:0] got;
        logic [47:0] orig [5];
        logic [47:0] scr  [5];
        @(negedge clk);
        do_reset();

        foreach (VEC[k]) step(VEC[k].fs, VEC[k].vin, VEC[k].d, "R1-table", got);

        // R10: scramble a frame, then descramble it after a fresh reset
        orig[0] = 48'hF6F6F6282828;
        orig[1] = 48'h0123456789AB;
        orig[2] = 48'hFEDCBA987654;
        orig[3] = 48'h00FF00FF00FF;
        orig[4] = 48'h3C3C3C3C3C3C;
        do_reset();
        for (int i = 0; i < 5; i++) begin
            step(i == 0, 1'b1, orig[i], "R10 scramble", got);
            scr[i] = got;
        end
        do_reset();
        for (int i = 0; i < 5; i++) begin
            frame_start = (i == 0);
            valid_in    = 1'b1;
            data_in     = scr[i];
            @(negedge clk);
            check("R10", data_out, orig[i], valid_out, 1'b1);
        end

        // R11: reset in mid-stream returns idle outputs and seed
        do_reset();
        step(1'b0, 1'b1, 48'h0, "R11 seed after reset", got);
        step(1'b0, 1'b0, 48'h0, "R2", got);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule